// File: doc/BRIEF.md
# Calibration Command Decoder with Coefficient Store

This block sits between a test-system command channel and a sensor compensation datapath. Each accepted command carries a 4-bit code, a 7-bit address and a 16-bit data word. The block decodes the code and then does one of four things. It writes a coefficient into one of eight 16-bit registers. It clears or sets bits in a 128-bit store that stands in for nonvolatile memory. It starts a conversion. Or it does nothing. The eight registers are presented side by side on one flat bus to the compensation datapath.

A start command carries two option bits. Code bit 1 asks for all eight registers to be refreshed from the 128-bit store before the conversion begins. Code bit 2 turns the serial data outputs off for the conversion. The store models memory that can only be bulk-erased to zero or programmed one bit at a time to one, and it keeps its contents through reset. Register 0 holds configuration. Two of its bits are decoded here to give an auxiliary-amplifier enable and a repeat-conversion flag.

Top module: `cal_cmd_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, all eight coefficient registers read zero, `conv_start` is 0 and `sout_en` is 0.
- R2: An accepted code 0x1 loads `cmd_data` into register `cmd_addr[2:0]`, which occupies `coef_bus[16*k +: 16]`. The upper address bits are ignored, and the new value is visible after the accepting clock edge.
- R3: An accepted code 0x4 clears all 128 store bits to 0.
- R4: An accepted code 0x2 sets store bit `cmd_addr` to 1. Bit index i belongs to register i/16 at bit position i%16, and every other store bit keeps its value.
- R5: Start codes with bit 1 set (0xA, 0xE) copy the store into all eight registers at the accepting edge. Start codes with bit 1 clear (0x8, 0xC) leave the registers unchanged.
- R6: Every accepted start code (0x8, 0xA, 0xC, 0xE) produces `conv_start` high for exactly one cycle. The pulse is registered at the second rising edge after acceptance, so any reload is already visible while the pulse is high.
- R7: Start codes with bit 2 clear (0x8, 0xA) set `sout_en` to 1, and those with bit 2 set (0xC, 0xE) clear it to 0. No other command changes `sout_en`.
- R8: Code 0x0 and the reserved codes 0x3, 0x5, 0x6, 0x7, 0x9, 0xB, 0xD and 0xF change no register, no store bit and no output.
- R9: A command presented while `cmd_vld` is low has no effect.
- R10: `cfg_amp_en` follows bit 12 of register 0, and `cfg_repeat` follows bit 13 of register 0.
- R11: Reset does not change the store. A reload after reset restores the bits programmed before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_vld | input | 1 | Command strobe; a command is taken at a rising edge while high |
| cmd_code | input | 4 | Command code |
| cmd_addr | input | 7 | Store bit index; low 3 bits select the register for writes |
| cmd_data | input | 16 | Coefficient value for register writes |
| coef_bus | output | 128 | Eight registers, register k at bits 16k+15..16k |
| cfg_amp_en | output | 1 | Auxiliary amplifier enable from register 0 |
| cfg_repeat | output | 1 | Repeat-conversion flag from register 0 |
| sout_en | output | 1 | Serial data output enable |
| conv_start | output | 1 | One-cycle conversion start pulse |

## Verification
The assertions assume three things about the inputs. No command arrives during reset. No command arrives in the two cycles after reset release, while the internal release synchronizer is still holding the block in reset. No start command is presented within two cycles before reset is applied. The bench keeps to these assumptions. It drives commands only on falling edges, holds `cmd_vld` low throughout every reset pulse, and waits several idle cycles after each release before issuing the next command. The contents of the store are checked only through the ports: the bench issues reload starts and compares every register against a bit model kept in the bench.

// File: rtl/cal_pkg.sv
package cal_pkg;

  typedef enum logic [3:0] {
    CMD_IDLE       = 4'h0,
    CMD_COEF_WR    = 4'h1,
    CMD_NV_SET     = 4'h2,
    CMD_NV_WIPE    = 4'h4,
    CMD_GO         = 4'h8,
    CMD_GO_LOAD    = 4'hA,
    CMD_GO_MUTE    = 4'hC,
    CMD_GO_LOAD_MU = 4'hE
  } cal_cmd_e;

  typedef struct packed {
    logic coef_wr;
    logic nv_set;
    logic nv_wipe;
    logic go;
    logic load;
    logic mute;
  } cal_op_t;

endpackage

// File: rtl/cal_cmd_dec.sv
module cal_cmd_dec
  import cal_pkg::*;
(
  input  logic       vld_i,
  input  logic [3:0] code_i,
  output cal_op_t    op_o
);

  always_comb begin
    op_o = '0;
    if (vld_i) begin
      unique case (code_i)
        CMD_COEF_WR:    op_o.coef_wr = 1'b1;
        CMD_NV_SET:     op_o.nv_set  = 1'b1;
        CMD_NV_WIPE:    op_o.nv_wipe = 1'b1;
        CMD_GO: begin
          op_o.go = 1'b1;
        end
        CMD_GO_LOAD: begin
          op_o.go   = 1'b1;
          op_o.load = 1'b1;
        end
        CMD_GO_MUTE: begin
          op_o.go   = 1'b1;
          op_o.mute = 1'b1;
        end
        CMD_GO_LOAD_MU: begin
          op_o.go   = 1'b1;
          op_o.load = 1'b1;
          op_o.mute = 1'b1;
        end
        default: op_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/cal_nv_array.sv
module cal_nv_array #(
  parameter int NBITS = 128,
  localparam int IW   = $clog2(NBITS)
) (
  input  logic             clk,
  input  logic             wipe_i,
  input  logic             set_i,
  input  logic [IW-1:0]    set_idx_i,
  output logic [NBITS-1:0] bits_o
);

  for (genvar gi = 0; gi < NBITS; gi++) begin : g_cell
    logic hit;
    logic cell_en;
    logic cell_d;
    logic cell_q;

    assign hit     = set_i && (set_idx_i == IW'(gi));
    assign cell_en = wipe_i || hit;

    always_comb begin
      cell_d = cell_q;
      if (wipe_i) begin
        cell_d = 1'b0;
      end else if (hit) begin
        cell_d = 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (cell_en) begin
        cell_q <= cell_d;
      end
    end

    assign bits_o[gi] = cell_q;
  end

endmodule

// File: rtl/cal_coef_rf.sv
module cal_coef_rf #(
  parameter int NREG = 8,
  parameter int DW   = 16,
  localparam int AW  = $clog2(NREG),
  localparam int FW  = NREG * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [AW-1:0] wr_idx_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          load_i,
  input  logic [FW-1:0] load_data_i,
  output logic [FW-1:0] regs_o
);

  for (genvar gr = 0; gr < NREG; gr++) begin : g_reg
    logic          sel;
    logic          reg_en;
    logic [DW-1:0] reg_d;
    logic [DW-1:0] reg_q;

    assign sel    = wr_i && (wr_idx_i == AW'(gr));
    assign reg_en = load_i || sel;

    always_comb begin
      reg_d = reg_q;
      if (load_i) begin
        reg_d = load_data_i[gr*DW +: DW];
      end else if (sel) begin
        reg_d = wr_data_i;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        reg_q <= '0;
      end else if (reg_en) begin
        reg_q <= reg_d;
      end
    end

    assign regs_o[gr*DW +: DW] = reg_q;
  end

endmodule

// File: rtl/cal_cmd_ctrl.sv
module cal_cmd_ctrl
  import cal_pkg::*;
#(
  parameter int NREG    = 8,
  parameter int DW      = 16,
  parameter int AMP_BIT = 12,
  parameter int RPT_BIT = 13,
  localparam int NBITS  = NREG * DW,
  localparam int IW     = $clog2(NBITS),
  localparam int AW     = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_vld,
  input  logic [3:0]       cmd_code,
  input  logic [IW-1:0]    cmd_addr,
  input  logic [DW-1:0]    cmd_data,
  output logic [NBITS-1:0] coef_bus,
  output logic             cfg_amp_en,
  output logic             cfg_repeat,
  output logic             sout_en,
  output logic             conv_start
);

  // reset release synchronizer
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[1];

  // command decode
  cal_op_t          op;
  logic [NBITS-1:0] nv_bits;

  cal_cmd_dec u_dec (
    .vld_i  (cmd_vld && rst_int_n),
    .code_i (cmd_code),
    .op_o   (op)
  );

  cal_nv_array #(.NBITS(NBITS)) u_nv (
    .clk       (clk),
    .wipe_i    (op.nv_wipe),
    .set_i     (op.nv_set),
    .set_idx_i (cmd_addr),
    .bits_o    (nv_bits)
  );

  cal_coef_rf #(.NREG(NREG), .DW(DW)) u_rf (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .wr_i        (op.coef_wr),
    .wr_idx_i    (cmd_addr[AW-1:0]),
    .wr_data_i   (cmd_data),
    .load_i      (op.go && op.load),
    .load_data_i (nv_bits),
    .regs_o      (coef_bus)
  );

  // output enable and start pulse pipeline
  logic sout_d, sout_q;
  logic go_d, go_q;
  logic pulse_d, pulse_q;

  always_comb begin
    sout_d  = sout_q;
    if (op.go) begin
      sout_d = !op.mute;
    end
    go_d    = op.go;
    pulse_d = go_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      sout_q  <= 1'b0;
      go_q    <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      sout_q  <= sout_d;
      go_q    <= go_d;
      pulse_q <= pulse_d;
    end
  end

  assign sout_en    = sout_q;
  assign conv_start = pulse_q;
  assign cfg_amp_en = coef_bus[AMP_BIT];
  assign cfg_repeat = coef_bus[RPT_BIT];

endmodule

// File: rtl/cal_cmd_ctrl_chk.sv
module cal_cmd_ctrl_chk #(
  parameter int NREG    = 8,
  parameter int DW      = 16,
  parameter int AMP_BIT = 12,
  parameter int RPT_BIT = 13,
  localparam int NBITS  = NREG * DW,
  localparam int AW     = $clog2(NREG)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_vld,
  input logic [3:0]       cmd_code,
  input logic [AW-1:0]    cmd_sel,
  input logic [DW-1:0]    cmd_data,
  input logic [NBITS-1:0] coef_bus,
  input logic             cfg_amp_en,
  input logic             cfg_repeat,
  input logic             sout_en,
  input logic             conv_start
);

  logic start_acc, loud_acc, mute_acc, idle_acc, wr_acc;

  assign start_acc = cmd_vld && cmd_code[3] && !cmd_code[0];
  assign loud_acc  = start_acc && !cmd_code[2];
  assign mute_acc  = start_acc && cmd_code[2];
  assign wr_acc    = cmd_vld && (cmd_code == 4'h1);
  assign idle_acc  = cmd_vld && (cmd_code == 4'h0 || (cmd_code[0] && cmd_code != 4'h1)
                     || cmd_code == 4'h6);

  function automatic logic [DW-1:0] slot(input logic [NBITS-1:0] b, input logic [AW-1:0] k);
    return b[k*DW +: DW];
  endfunction

  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> slot(coef_bus, $past(cmd_sel)) == $past(cmd_data));

  a_r6_pulse_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> ##1 conv_start);

  a_r6_pulse_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> $past(start_acc, 2));

  a_r7_loud_sets: assert property (@(posedge clk) disable iff (!rst_n)
    loud_acc |=> sout_en);

  a_r7_mute_clears: assert property (@(posedge clk) disable iff (!rst_n)
    mute_acc |=> !sout_en);

  a_r7_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !start_acc |=> $stable(sout_en));

  a_r8_idle_inert: assert property (@(posedge clk) disable iff (!rst_n)
    idle_acc |=> $stable(coef_bus) && $stable(sout_en));

  a_r9_novld_inert: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_vld |=> $stable(coef_bus) && $stable(sout_en));

  a_r10_cfg_bits: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_amp_en == coef_bus[AMP_BIT] && cfg_repeat == coef_bus[RPT_BIT]);

endmodule

bind cal_cmd_ctrl cal_cmd_ctrl_chk #(
  .NREG(NREG), .DW(DW), .AMP_BIT(AMP_BIT), .RPT_BIT(RPT_BIT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_vld    (cmd_vld),
  .cmd_code   (cmd_code),
  .cmd_sel    (cmd_addr[AW-1:0]),
  .cmd_data   (cmd_data),
  .coef_bus   (coef_bus),
  .cfg_amp_en (cfg_amp_en),
  .cfg_repeat (cfg_repeat),
  .sout_en    (sout_en),
  .conv_start (conv_start)
);

// File: tb/cal_cmd_ctrl_bench.sv
module cal_cmd_ctrl_bench;

  logic         clk;
  logic         rst_n;
  logic         cmd_vld;
  logic [3:0]   cmd_code;
  logic [6:0]   cmd_addr;
  logic [15:0]  cmd_data;
  logic [127:0] coef_bus;
  logic         cfg_amp_en, cfg_repeat, sout_en, conv_start;

  int n_chk;
  int n_bad;

  logic [127:0] m_reg;
  logic [127:0] m_nv;
  logic         m_sout;

  cal_cmd_ctrl u_cal_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_code(cmd_code),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .coef_bus(coef_bus),
    .cfg_amp_en(cfg_amp_en), .cfg_repeat(cfg_repeat), .sout_en(sout_en),
    .conv_start(conv_start)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one command for one cycle; bench model follows the requirements
  task automatic send(input logic [3:0] c, input logic [6:0] a, input logic [15:0] d);
    @(negedge clk);
    cmd_vld = 1'b1; cmd_code = c; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_vld = 1'b0;
    case (c)
      4'h1: m_reg[a[2:0]*16 +: 16] = d;
      4'h2: m_nv[a] = 1'b1;
      4'h4: m_nv = '0;
      4'h8, 4'hA, 4'hC, 4'hE: begin
        if (c[1]) m_reg = m_nv;
        m_sout = !c[2];
      end
      default: ;
    endcase
  endtask

  task automatic do_reset();
    @(negedge clk);
    cmd_vld = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 regs in reset", coef_bus, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_reg = '0;
    m_sout = 1'b0;
  endtask

  task automatic pulse_seen(input string tag, input bit expect_pulse);
    // called right after send: pulse appears one cycle later, for one cycle
    chk({tag, " pre"}, 128'(conv_start), 128'(0));
    @(negedge clk);
    chk({tag, " pulse"}, 128'(conv_start), 128'(expect_pulse));
    @(negedge clk);
    chk({tag, " post"}, 128'(conv_start), 128'(0));
  endtask

  task automatic t_reset_state();
    chk("R1 coef after reset", coef_bus, '0);
    chk("R1 conv_start after reset", 128'(conv_start), 128'(0));
    chk("R1 sout_en after reset", 128'(sout_en), 128'(0));
  endtask

  task automatic t_coef_write();
    send(4'h1, 7'h7B, 16'hBEEF);
    chk("R2 write reg3 high addr bits ignored", coef_bus, m_reg);
    send(4'h1, 7'h00, 16'h3000);
    chk("R2 write reg0", coef_bus, m_reg);
    chk("R10 amp enable", 128'(cfg_amp_en), 128'(1));
    chk("R10 repeat", 128'(cfg_repeat), 128'(1));
    send(4'h1, 7'h00, 16'h1000);
    chk("R10 repeat cleared", 128'(cfg_repeat), 128'(0));
    send(4'h1, 7'h07, 16'h8001);
    chk("R2 write reg7", coef_bus, m_reg);
  endtask

  task automatic t_nv_program_reload();
    send(4'h4, 7'h00, 16'h0);
    send(4'h2, 7'h05, 16'h0);
    send(4'h2, 7'h7F, 16'h0);
    send(4'h2, 7'h2A, 16'hFFFF);
    send(4'hA, 7'h00, 16'h0);
    chk("R4 R5 reload shows set bits", coef_bus, m_reg);
    chk("R4 expected pattern", coef_bus,
        (128'h1 << 5) | (128'h1 << 127) | (128'h1 << 42));
    pulse_seen("R6 start 0xA", 1'b1);
    chk("R7 sout_en after 0xA", 128'(sout_en), 128'(1));
  endtask

  task automatic t_start_no_reload();
    send(4'h1, 7'h01, 16'h1234);
    send(4'hC, 7'h00, 16'h0);
    chk("R5 0xC keeps registers", coef_bus, m_reg);
    pulse_seen("R6 start 0xC", 1'b1);
    chk("R7 sout_en after 0xC", 128'(sout_en), 128'(0));
    send(4'h8, 7'h00, 16'h0);
    chk("R5 0x8 keeps registers", coef_bus, m_reg);
    pulse_seen("R6 start 0x8", 1'b1);
    chk("R7 sout_en after 0x8", 128'(sout_en), 128'(1));
  endtask

  task automatic t_reserved();
    logic [3:0] codes [9] = '{4'h0, 4'h3, 4'h5, 4'h6, 4'h7, 4'h9, 4'hB, 4'hD, 4'hF};
    for (int i = 0; i < 9; i++) begin
      send(codes[i], 7'h11, 16'hA5A5);
      chk("R8 code no reg change", coef_bus, m_reg);
      chk("R8 code no sout change", 128'(sout_en), 128'(m_sout));
      pulse_seen("R8 code no pulse", 1'b0);
    end
    send(4'hE, 7'h00, 16'h0);
    chk("R8 store untouched by reserved codes", coef_bus, m_reg);
    pulse_seen("R6 start 0xE", 1'b1);
    chk("R7 sout_en after 0xE", 128'(sout_en), 128'(0));
  endtask

  task automatic t_no_strobe();
    @(negedge clk);
    cmd_vld = 1'b0; cmd_code = 4'h1; cmd_addr = 7'h02; cmd_data = 16'h7777;
    @(negedge clk);
    cmd_code = 4'h8;
    @(negedge clk);
    cmd_code = 4'h4;
    repeat (3) @(negedge clk);
    chk("R9 no strobe regs", coef_bus, m_reg);
    chk("R9 no strobe sout", 128'(sout_en), 128'(m_sout));
    chk("R9 no strobe pulse", 128'(conv_start), 128'(0));
    send(4'hA, 7'h00, 16'h0);
    chk("R9 store kept without strobe", coef_bus, m_reg);
  endtask

  task automatic t_reset_keeps_store();
    send(4'h2, 7'h30, 16'h0);
    do_reset();
    chk("R1 regs cleared by reset", coef_bus, '0);
    chk("R1 sout_en cleared by reset", 128'(sout_en), 128'(0));
    send(4'hA, 7'h00, 16'h0);
    chk("R11 store survives reset", coef_bus, m_reg);
    chk("R11 bit 0x30 present", 128'(coef_bus[48]), 128'(1));
  endtask

  task automatic t_erase();
    send(4'h4, 7'h00, 16'h0);
    send(4'h1, 7'h04, 16'hFFFF);
    send(4'hE, 7'h00, 16'h0);
    chk("R3 erase then reload all zero", coef_bus, '0);
  endtask

  initial begin
    n_chk = 0; n_bad = 0;
    m_reg = '0; m_nv = '0; m_sout = 1'b0;
    rst_n = 1'b0; cmd_vld = 1'b0; cmd_code = '0; cmd_addr = '0; cmd_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_state();
    t_coef_write();
    t_nv_program_reload();
    t_start_no_reload();
    t_reserved();
    t_no_strobe();
    t_reset_keeps_store();
    t_erase();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule